// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block buffers instructions bound for a single functional unit in an out-of-order core. Instructions arrive one per cycle, in program order, through one issue port. Each carries an opcode and two source operands. An operand is either a value that is already known or a tag that names the producer of that value. Pending instructions stay in one of four slots. Every slot watches a result bus that carries a tag and a value. When a tag on the bus matches an operand the slot is still missing, the slot copies the value straight from the bus. A rename table, register file, commit logic and the unit's arithmetic are all outside this block.

When at least one slot has both operands and the functional unit reports that it is free, the station hands the oldest such instruction to the unit. The result of that instruction will later come back on the result bus under the slot's own tag, so the tag stays reserved until that result has been broadcast. A single synchronous flush empties the station.

Top module: `rs_station`

## Requirements
- R1: After reset, no slot is occupied: `full` is 0 and `disp_valid` is 0 even when `fu_ready` is 1.
- R2: An instruction is accepted only in a cycle where `iss_valid` is 1 and `full` is 0. An instruction presented while `full` is 1 is dropped and is never dispatched later.
- R3: `full` is 1 exactly when each of the four slots either holds an instruction or is waiting for the broadcast of its own tag.
- R4: A source with `*_rdy`=1 keeps its value from issue. A source with `*_rdy`=0 waits. In any later cycle where `cdb_valid` is 1 and `cdb_tag` equals its tag, it takes `cdb_data`. Every waiting source in every slot makes this comparison.
- R5: If the bus broadcasts the awaited tag in the same cycle that an instruction is issued, the new slot takes the bus value immediately and does not need a second broadcast.
- R6: `disp_valid` is 1 only when `fu_ready` is 1 and some slot has both sources valid. The dispatch happens at the clock edge of that cycle.
- R7: When several slots are ready, the one issued earliest is dispatched, whatever its slot number.
- R8: `disp_tag` equals 4 plus the slot number (tags 4 to 7 belong to this station). The slot is released when it dispatches, but it cannot take a new instruction until `cdb_tag` equals its tag with `cdb_valid` set. A free slot is filled lowest number first.
- R9: When `flush` is 1 at a clock edge, every slot and every reserved tag is cleared.
- R10: `disp_op`, `disp_a` and `disp_b` equal the issued opcode and the source values held or captured by the dispatched slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of all slots |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Opcode of the issued instruction |
| iss_a_rdy | input | 1 | Source A value is known |
| iss_a_tag | input | 3 | Producer tag of source A |
| iss_a_val | input | 16 | Value of source A |
| iss_b_rdy | input | 1 | Source B value is known |
| iss_b_tag | input | 3 | Producer tag of source B |
| iss_b_val | input | 16 | Value of source B |
| full | output | 1 | No slot can accept an issue |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | 3 | Tag of the broadcast result |
| cdb_data | input | 16 | Value of the broadcast result |
| fu_ready | input | 1 | Functional unit can take an instruction |
| disp_valid | output | 1 | Instruction handed to the unit this cycle |
| disp_op | output | 4 | Dispatched opcode |
| disp_a | output | 16 | Dispatched source A |
| disp_b | output | 16 | Dispatched source B |
| disp_tag | output | 3 | Tag under which the result must return |

## Verification
The assertions assume that a tag from 4 to 7 appears on the result bus only after the matching slot has dispatched and before that slot is reused. They also assume that only one result is broadcast per cycle and that a waiting source never names a tag that is no longer in flight. The stimulus follows these rules. It broadcasts this station's tags only to return results it has already seen dispatched. It uses tags 0 to 3 as external producers for the waiting sources. It keeps the bus to one result per cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int RS_DEPTH = 4;
    localparam int DATA_W   = 16;
    localparam int OP_W     = 4;
    localparam int TAG_W    = 3;
    localparam int IDX_W    = $clog2(RS_DEPTH);
    localparam int RANK_W   = IDX_W;
    localparam int CNT_W    = IDX_W + 1;

    localparam logic [TAG_W-1:0] RS_TAG_BASE = 3'd4;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } rs_src_t;

    typedef struct packed {
        logic [OP_W-1:0] op;
        rs_src_t         a;
        rs_src_t         b;
    } rs_instr_t;

    // Take the bus value if the source is still waiting on that tag
    function automatic rs_src_t snoop(input rs_src_t s,
                                      input logic cv,
                                      input logic [TAG_W-1:0] ct,
                                      input logic [DATA_W-1:0] cd);
        rs_src_t r;
        r = s;
        if (!s.rdy && cv && (s.tag == ct)) begin
            r.rdy = 1'b1;
            r.val = cd;
        end
        return r;
    endfunction

    function automatic logic [TAG_W-1:0] own_tag(input logic [IDX_W-1:0] idx);
        return RS_TAG_BASE + TAG_W'(idx);
    endfunction

endpackage

// File: rtl/rs_alloc.sv
module rs_alloc
    import rs_pkg::*;
(
    input  logic [RS_DEPTH-1:0] occupied,
    output logic [RS_DEPTH-1:0] alloc_oh,
    output logic                full
);

    logic taken;

    always_comb begin
        alloc_oh = '0;
        taken    = 1'b0;
        for (int i = 0; i < RS_DEPTH; i++) begin
            if (!occupied[i] && !taken) begin
                alloc_oh[i] = 1'b1;
                taken       = 1'b1;
            end
        end
    end

    assign full = &occupied;

endmodule

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              alloc_en,
    input  rs_instr_t         iss_in,
    input  logic [RANK_W-1:0] new_rank,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              disp_en,
    input  logic              disp_fire,
    input  logic [RANK_W-1:0] disp_rank,
    output logic              valid_o,
    output logic              inflight_o,
    output logic              ready_o,
    output logic [RANK_W-1:0] rank_o,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);

    localparam logic [TAG_W-1:0] MY_TAG = own_tag(IDX_W'(SLOT));

    logic              valid_q;
    logic              inflight_q;
    logic [RANK_W-1:0] rank_q;
    rs_instr_t         instr_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q    <= 1'b0;
            inflight_q <= 1'b0;
            rank_q     <= '0;
            instr_q    <= '0;
        end else begin
            if (alloc_en) begin
                valid_q    <= 1'b1;
                rank_q     <= new_rank;
                instr_q.op <= iss_in.op;
                instr_q.a  <= snoop(iss_in.a, cdb_valid, cdb_tag, cdb_data);
                instr_q.b  <= snoop(iss_in.b, cdb_valid, cdb_tag, cdb_data);
            end else if (valid_q) begin
                instr_q.a <= snoop(instr_q.a, cdb_valid, cdb_tag, cdb_data);
                instr_q.b <= snoop(instr_q.b, cdb_valid, cdb_tag, cdb_data);
                if (disp_en) begin
                    valid_q    <= 1'b0;
                    inflight_q <= 1'b1;
                end else if (disp_fire && (rank_q > disp_rank)) begin
                    rank_q <= rank_q - RANK_W'(1);
                end
            end
            if (inflight_q && cdb_valid && (cdb_tag == MY_TAG)) begin
                inflight_q <= 1'b0;
            end
        end
    end

    assign valid_o    = valid_q;
    assign inflight_o = inflight_q;
    assign ready_o    = valid_q && instr_q.a.rdy && instr_q.b.rdy;
    assign rank_o     = rank_q;
    assign op_o       = instr_q.op;
    assign a_o        = instr_q.a.val;
    assign b_o        = instr_q.b.val;

endmodule

// File: rtl/rs_select.sv
module rs_select
    import rs_pkg::*;
(
    input  logic [RS_DEPTH-1:0] ready,
    input  logic [RANK_W-1:0]   rank [RS_DEPTH],
    output logic                any_ready,
    output logic [IDX_W-1:0]    pick_idx,
    output logic [RANK_W-1:0]   pick_rank
);

    always_comb begin
        any_ready = 1'b0;
        pick_idx  = '0;
        pick_rank = '0;
        for (int i = 0; i < RS_DEPTH; i++) begin
            if (ready[i] && (!any_ready || (rank[i] < pick_rank))) begin
                any_ready = 1'b1;
                pick_idx  = IDX_W'(i);
                pick_rank = rank[i];
            end
        end
    end

endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic              iss_a_rdy,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic              iss_b_rdy,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    output logic              full,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              fu_ready,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag
);

    rs_instr_t           iss_instr;
    logic [RS_DEPTH-1:0] valid_vec;
    logic [RS_DEPTH-1:0] inflight_vec;
    logic [RS_DEPTH-1:0] ready_vec;
    logic [RS_DEPTH-1:0] alloc_oh;
    logic [RANK_W-1:0]   rank_arr [RS_DEPTH];
    logic [OP_W-1:0]     op_arr   [RS_DEPTH];
    logic [DATA_W-1:0]   a_arr    [RS_DEPTH];
    logic [DATA_W-1:0]   b_arr    [RS_DEPTH];
    logic                iss_fire;
    logic                any_ready;
    logic                disp_fire;
    logic [IDX_W-1:0]    pick_idx;
    logic [RANK_W-1:0]   pick_rank;
    logic [CNT_W-1:0]    live_cnt;
    logic [RANK_W-1:0]   new_rank;

    assign iss_instr.op    = iss_op;
    assign iss_instr.a.rdy = iss_a_rdy;
    assign iss_instr.a.tag = iss_a_tag;
    assign iss_instr.a.val = iss_a_val;
    assign iss_instr.b.rdy = iss_b_rdy;
    assign iss_instr.b.tag = iss_b_tag;
    assign iss_instr.b.val = iss_b_val;

    rs_alloc u_alloc (
        .occupied (valid_vec | inflight_vec),
        .alloc_oh (alloc_oh),
        .full     (full)
    );

    assign iss_fire = iss_valid && !full;

    // Age: rank counts the older live entries; a new entry ranks behind them all
    always_comb begin
        live_cnt = '0;
        for (int i = 0; i < RS_DEPTH; i++) begin
            live_cnt = live_cnt + CNT_W'(valid_vec[i]);
        end
    end
    assign new_rank = RANK_W'(live_cnt - CNT_W'(disp_fire));

    for (genvar g = 0; g < RS_DEPTH; g++) begin : g_slot
        rs_entry #(.SLOT(g)) u_entry (
            .clk        (clk),
            .rst        (rst),
            .flush      (flush),
            .alloc_en   (iss_fire && alloc_oh[g]),
            .iss_in     (iss_instr),
            .new_rank   (new_rank),
            .cdb_valid  (cdb_valid),
            .cdb_tag    (cdb_tag),
            .cdb_data   (cdb_data),
            .disp_en    (disp_fire && (pick_idx == IDX_W'(g))),
            .disp_fire  (disp_fire),
            .disp_rank  (pick_rank),
            .valid_o    (valid_vec[g]),
            .inflight_o (inflight_vec[g]),
            .ready_o    (ready_vec[g]),
            .rank_o     (rank_arr[g]),
            .op_o       (op_arr[g]),
            .a_o        (a_arr[g]),
            .b_o        (b_arr[g])
        );
    end

    rs_select u_select (
        .ready     (ready_vec),
        .rank      (rank_arr),
        .any_ready (any_ready),
        .pick_idx  (pick_idx),
        .pick_rank (pick_rank)
    );

    assign disp_fire  = any_ready && fu_ready;
    assign disp_valid = disp_fire;
    assign disp_op    = op_arr[pick_idx];
    assign disp_a     = a_arr[pick_idx];
    assign disp_b     = b_arr[pick_idx];
    assign disp_tag   = own_tag(pick_idx);

endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk
    import rs_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                flush,
    input logic                full,
    input logic                fu_ready,
    input logic                disp_valid,
    input logic [TAG_W-1:0]    disp_tag,
    input logic [RS_DEPTH-1:0] valid_vec,
    input logic [RS_DEPTH-1:0] inflight_vec,
    input logic [RANK_W-1:0]   rank_arr [RS_DEPTH]
);

    logic [IDX_W-1:0]    d_idx;
    logic [RS_DEPTH-1:0] head_vec;

    assign d_idx = IDX_W'(disp_tag - RS_TAG_BASE);

    always_comb begin
        for (int i = 0; i < RS_DEPTH; i++) begin
            head_vec[i] = valid_vec[i] && (rank_arr[i] == '0);
        end
    end

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0) && (inflight_vec == '0));

    // R6
    fu_busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fu_ready |-> !disp_valid);

    // R3
    full_occupied_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> &(valid_vec | inflight_vec));

    // R2
    no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !flush) |=> ((valid_vec & ~$past(valid_vec)) == '0));

    // R8
    disp_from_live_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> valid_vec[d_idx] && !inflight_vec[d_idx]);

    // R8
    tag_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !flush) |=> inflight_vec[$past(d_idx)] && !valid_vec[$past(d_idx)]);

    // R7
    single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        (|valid_vec) |-> ($countones(head_vec) == 1));

endmodule

bind rs_station rs_station_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .full         (full),
    .fu_ready     (fu_ready),
    .disp_valid   (disp_valid),
    .disp_tag     (disp_tag),
    .valid_vec    (valid_vec),
    .inflight_vec (inflight_vec),
    .rank_arr     (rank_arr)
);

// File: tb/rs_station_tb.sv
module rs_station_tb;
    import rs_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              flush = 1'b0;
    logic              iss_valid = 1'b0;
    logic [OP_W-1:0]   iss_op = '0;
    logic              iss_a_rdy = 1'b0;
    logic [TAG_W-1:0]  iss_a_tag = '0;
    logic [DATA_W-1:0] iss_a_val = '0;
    logic              iss_b_rdy = 1'b0;
    logic [TAG_W-1:0]  iss_b_tag = '0;
    logic [DATA_W-1:0] iss_b_val = '0;
    logic              full;
    logic              cdb_valid = 1'b0;
    logic [TAG_W-1:0]  cdb_tag = '0;
    logic [DATA_W-1:0] cdb_data = '0;
    logic              fu_ready = 1'b0;
    logic              disp_valid;
    logic [OP_W-1:0]   disp_op;
    logic [DATA_W-1:0] disp_a;
    logic [DATA_W-1:0] disp_b;
    logic [TAG_W-1:0]  disp_tag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rs_station u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_rdy(iss_a_rdy), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_rdy(iss_b_rdy), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .full(full), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .fu_ready(fu_ready), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
        flush     = 1'b0;
    endtask

    task automatic set_issue(input int op, input bit ar, input int at, input int av,
                             input bit br, input int bv);
        iss_valid = 1'b1;
        iss_op    = OP_W'(op);
        iss_a_rdy = ar;
        iss_a_tag = TAG_W'(at);
        iss_a_val = DATA_W'(av);
        iss_b_rdy = br;
        iss_b_tag = '0;
        iss_b_val = DATA_W'(bv);
    endtask

    task automatic issue(input int op, input bit ar, input int at, input int av,
                         input bit br, input int bv);
        set_issue(op, ar, at, av, br, bv);
        cyc();
    endtask

    task automatic set_bcast(input int tag, input int data);
        cdb_valid = 1'b1;
        cdb_tag   = TAG_W'(tag);
        cdb_data  = DATA_W'(data);
    endtask

    task automatic bcast(input int tag, input int data);
        set_bcast(tag, data);
        cyc();
    endtask

    task automatic expect_disp(input string req, input int op, input int a, input int b, input int tag);
        chk(req, "disp_valid", int'(disp_valid), 1);
        chk(req, "disp_op", int'(disp_op), op);
        chk(req, "disp_a", int'(disp_a), a);
        chk(req, "disp_b", int'(disp_b), b);
        chk(req, "disp_tag", int'(disp_tag), tag);
    endtask

    initial begin
        cyc(); rst = 1'b1; cyc(); cyc(); rst = 1'b0;

        // R1: empty after reset
        fu_ready = 1'b1; #1;
        chk("R1", "full", int'(full), 0);
        chk("R1", "disp_valid", int'(disp_valid), 0);
        fu_ready = 1'b0;

        // R6, R10, R8: basic dispatch and tag reservation
        issue(1, 1, 0, 10, 1, 20);
        #1; chk("R6", "disp_valid while unit busy", int'(disp_valid), 0);
        fu_ready = 1'b1; #1;
        expect_disp("R10", 1, 10, 20, 4);
        cyc(); fu_ready = 1'b0;
        issue(2, 1, 0, 1, 1, 2);
        fu_ready = 1'b1; #1;
        expect_disp("R8", 2, 1, 2, 5);   // slot 0 still reserved
        cyc(); fu_ready = 1'b0;
        bcast(4, 0);
        bcast(5, 0);

        // R3, R4, R2: fill with waiting entries, drop an issue while full
        for (int i = 0; i < 4; i++) issue(3, 0, 1, 0, 1, 100 + i);
        #1; chk("R3", "full after four issues", int'(full), 1);
        issue(9, 1, 0, 1, 1, 555);
        chk("R2", "full after dropped issue", int'(full), 1);
        fu_ready = 1'b1; #1;
        chk("R4", "disp_valid before broadcast", int'(disp_valid), 0);
        fu_ready = 1'b0;
        bcast(1, 99);
        fu_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #1; expect_disp("R4", 3, 99, 100 + i, 4 + i);
            cyc();
        end
        #1; chk("R2", "disp_valid after four dispatches", int'(disp_valid), 0);
        fu_ready = 1'b0;
        chk("R8", "full while all tags reserved", int'(full), 1);
        for (int i = 0; i < 4; i++) bcast(4 + i, 0);
        chk("R3", "full after all tags returned", int'(full), 0);

        // R7: oldest ready wins over lower slot number
        issue(4, 1, 0, 1, 1, 1);        // slot 0
        issue(5, 1, 0, 2, 1, 2);        // slot 1
        issue(6, 0, 2, 0, 1, 3);        // slot 2, waits on tag 2
        fu_ready = 1'b1; #1;
        expect_disp("R7", 4, 1, 1, 4);
        cyc(); #1;
        expect_disp("R7", 5, 2, 2, 5);
        cyc(); #1;
        chk("R6", "disp_valid with no ready slot", int'(disp_valid), 0);
        fu_ready = 1'b0;
        bcast(4, 0);
        bcast(5, 0);
        issue(7, 1, 0, 8, 1, 9);        // lands in slot 0
        bcast(2, 42);
        fu_ready = 1'b1; #1;
        expect_disp("R7", 6, 42, 3, 6);
        cyc(); #1;
        expect_disp("R7", 7, 8, 9, 4);
        cyc(); fu_ready = 1'b0;
        bcast(6, 0);
        bcast(4, 0);

        // R5: broadcast in the issue cycle is captured
        set_issue(8, 0, 3, 0, 1, 5);
        set_bcast(3, 77);
        cyc();
        fu_ready = 1'b1; #1;
        expect_disp("R5", 8, 77, 5, 4);
        cyc(); fu_ready = 1'b0;
        bcast(4, 0);

        // R9: flush clears slots and reservations
        for (int i = 0; i < 4; i++) issue(10, 1, 0, i, 1, i);
        fu_ready = 1'b1; #1;
        expect_disp("R9", 10, 0, 0, 4);
        cyc(); fu_ready = 1'b0;
        flush = 1'b1; cyc();
        fu_ready = 1'b1; #1;
        chk("R9", "full after flush", int'(full), 0);
        chk("R9", "disp_valid after flush", int'(disp_valid), 0);
        fu_ready = 1'b0;
        issue(11, 1, 0, 33, 1, 44);
        fu_ready = 1'b1; #1;
        expect_disp("R9", 11, 33, 44, 4);
        cyc(); fu_ready = 1'b0;
        bcast(4, 0);

        // R4, R10: sweep of opcodes, producer tags and values
        for (int k = 0; k < 16; k++) begin
            issue(k, 0, k % 4, 0, 1, k * 3);
            bcast(k % 4, k * 7 + 1);
            fu_ready = 1'b1; #1;
            expect_disp("R10", k, k * 7 + 1, k * 3, 4);
            cyc(); fu_ready = 1'b0;
            bcast(4, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule